// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block sits on the inbound side of a bus bridge. It holds three programmable address windows. For each bus address presented to it, it decides whether the address falls into one of the windows and reports which one. It also produces the matching address in local system memory. Every window maps onto local memory starting at address zero, so the local address is the offset of the bus address inside its window.

Each window has one 32-bit control word. The word holds a 1 MB-aligned base, a 4-bit size code and an enable flag. Software programs the words through a simple write/read port. Requests use a valid-qualified address input. Each request produces a registered result exactly one clock later.

Top module: `inbound_window_decoder`

## Requirements
- R1: After reset, all three control words read as zero, rsp_valid is low, and a request for any address (including 0x0000_0000) returns a miss.
- R2: A control word keeps bits 31..20 (window base), bits 19..16 (size code) and bit 0 (enable). Bits 15..1 are discarded and read back as zero. The word for window w is selected by cfg_addr = w.
- R3: A write with cfg_addr = 3 changes no window, and a read at cfg_addr = 3 returns zero.
- R4: An enabled window with a legal size code k covers 2^(20+k) bytes. It hits when the address bits from bit (20+k) upward equal the stored base bits at the same positions. The base bits below bit (20+k) are ignored.
- R5: On a hit, rsp_local_addr equals the request address ANDed with (window size − 1). On a miss, rsp_local_addr and rsp_win are zero.
- R6: A window whose enable bit is 0 never hits.
- R7: Size codes 12 to 15 are illegal, and a window holding one of them never hits.
- R8: When more than one window hits, rsp_win reports the lowest-numbered hitting window, and the local address is taken from that window.
- R9: rsp_valid, rsp_hit, rsp_win and rsp_local_addr follow a request by exactly one clock. With no request, rsp_valid and rsp_hit are low in the next cycle.
- R10: Size code 11 gives a 2 GB window that compares only address bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_addr | input | 2 | Window index for the write or read |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data (combinational from cfg_addr) |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 32 | Incoming bus address |
| rsp_valid | output | 1 | Result valid, one clock after req_valid |
| rsp_hit | output | 1 | Address fell into an enabled, legal window |
| rsp_win | output | 2 | Index of the winning window |
| rsp_local_addr | output | 32 | Translated local address |

## Verification
A corrupted control word shows up on cfg_rdata in the same cycle the word is selected. It also shows up in the response to the next request that lands near that window. A wrong stored size code moves a window boundary, so the checks use addresses one byte on each side of each boundary. That way a one-step size error produces a miss or a wrong window index one clock after the request. Wrong priority or a lost enable shows up as a wrong rsp_win, or a hit that should be a miss, on the first request into an overlap.

// File: rtl/win_dec_pkg.sv
`timescale 1ns/1ps
package win_dec_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 20;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int CODE_LSB = 16;
  localparam int CODE_W   = 4;
  localparam int MAX_CODE = 11;
  localparam int RSV_W    = CODE_LSB - 1;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
    logic              en;
  } win_cfg_t;

  function automatic logic [ADDR_W-1:0] cfg_to_word(input win_cfg_t c);
    return {c.base, c.code, {RSV_W{1'b0}}, c.en};
  endfunction
endpackage

// File: rtl/win_dec_reg.sv
`timescale 1ns/1ps
module win_dec_reg
  import win_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BASE_W-1:0] base_in,
  input  logic [CODE_W-1:0] code_in,
  input  logic              en_in,
  output win_cfg_t          cfg_q
);
  win_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.base = base_in;
      cfg_d.code = code_in;
      cfg_d.en   = en_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/win_dec_match.sv
`timescale 1ns/1ps
module win_dec_match
  import win_dec_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] local_addr
);
  logic [5:0]        span;
  logic [ADDR_W-1:0] lo_mask;
  logic [ADDR_W-1:0] base_full;
  logic              legal;

  always_comb begin
    span      = 6'(BASE_LSB) + {2'b00, cfg.code};
    lo_mask   = (ADDR_W'(1) << span) - ADDR_W'(1);
    base_full = {cfg.base, {BASE_LSB{1'b0}}};
    legal     = ({2'b00, cfg.code} <= 6'(MAX_CODE));
    hit       = cfg.en && legal && ((addr & ~lo_mask) == (base_full & ~lo_mask));
    local_addr = addr & lo_mask;
  end
endmodule

// File: rtl/win_dec_select.sv
`timescale 1ns/1ps
module win_dec_select
  import win_dec_pkg::*;
#(
  parameter int NUM_WIN = 3,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0]             hit_vec,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] loc_vec,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               sel_idx,
  output logic [ADDR_W-1:0]              sel_loc
);
  always_comb begin
    any_hit = |hit_vec;
    sel_idx = '0;
    sel_loc = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_idx = IDX_W'(i);
        sel_loc = loc_vec[i];
      end
    end
  end
endmodule

// File: rtl/inbound_window_decoder.sv
`timescale 1ns/1ps
module inbound_window_decoder
  import win_dec_pkg::*;
#(
  parameter int NUM_WIN = 3,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_win,
  output logic [ADDR_W-1:0] rsp_local_addr
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic unused_wbits;
  assign unused_wbits = ^cfg_wdata[RSV_W:1];

  win_cfg_t [NUM_WIN-1:0]             cfg_q;
  logic     [NUM_WIN-1:0]             hit_vec;
  logic     [NUM_WIN-1:0][ADDR_W-1:0] loc_vec;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic wr_sel;
    assign wr_sel = cfg_we && (cfg_addr == IDX_W'(w));

    win_dec_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_en   (wr_sel),
      .base_in (cfg_wdata[ADDR_W-1:BASE_LSB]),
      .code_in (cfg_wdata[CODE_LSB+CODE_W-1:CODE_LSB]),
      .en_in   (cfg_wdata[0]),
      .cfg_q   (cfg_q[w])
    );

    win_dec_match u_match (
      .cfg        (cfg_q[w]),
      .addr       (req_addr),
      .hit        (hit_vec[w]),
      .local_addr (loc_vec[w])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (cfg_addr == IDX_W'(i)) cfg_rdata = cfg_to_word(cfg_q[i]);
    end
  end

  logic              any_hit;
  logic [IDX_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] sel_loc;

  win_dec_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .hit_vec (hit_vec),
    .loc_vec (loc_vec),
    .any_hit (any_hit),
    .sel_idx (sel_idx),
    .sel_loc (sel_loc)
  );

  // response stage: next-state
  logic              valid_d, hit_d, load_en;
  logic [IDX_W-1:0]  win_d;
  logic [ADDR_W-1:0] loc_d;

  always_comb begin
    load_en = req_valid;
    valid_d = req_valid;
    hit_d   = req_valid && any_hit;
    win_d   = any_hit ? sel_idx : '0;
    loc_d   = any_hit ? sel_loc : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_win        <= '0;
      rsp_local_addr <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      if (load_en) begin
        rsp_win        <= win_d;
        rsp_local_addr <= loc_d;
      end
    end
  end
endmodule

// File: rtl/inbound_window_decoder_chk.sv
`timescale 1ns/1ps
module inbound_window_decoder_chk #(
  parameter int NUM_WIN = 3,
  parameter int ADDR_W  = 32,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [IDX_W-1:0]  rsp_win,
  input logic [ADDR_W-1:0] rsp_local_addr
);
  assert_req_to_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_no_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_hit);

  assert_hit_has_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  assert_win_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (int'(rsp_win) < NUM_WIN));

  assert_miss_zeroed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_local_addr == '0 && rsp_win == '0));

  assert_local_below_2g_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> !rsp_local_addr[ADDR_W-1]);
endmodule

bind inbound_window_decoder inbound_window_decoder_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_int_n),
  .req_valid      (req_valid),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .rsp_win        (rsp_win),
  .rsp_local_addr (rsp_local_addr)
);

// File: tb/inbound_window_decoder_bench.sv
`timescale 1ns/1ps
module inbound_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_local_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  inbound_window_decoder u_inbound_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_win(rsp_win), .rsp_local_addr(rsp_local_addr)
  );

  // entry: {addr, hit, win, local}
  localparam int NV = 8;
  localparam logic [66:0] VEC [NV] = '{
    {32'h4000_1234, 1'b1, 2'd0, 32'h0000_1234},  // R4 R8 overlap, win0 wins
    {32'h403F_FFFF, 1'b1, 2'd0, 32'h003F_FFFF},  // R4 top byte of 4 MB
    {32'h4040_0000, 1'b1, 2'd1, 32'h0040_0000},  // R4 just past win0, into win1
    {32'h40FF_FFF0, 1'b1, 2'd1, 32'h00FF_FFF0},  // R5 offset in 16 MB
    {32'h4100_0000, 1'b0, 2'd0, 32'h0000_0000},  // R4 just past win1
    {32'h8000_0004, 1'b1, 2'd2, 32'h0000_0004},  // R10 low base bits ignored
    {32'hFFFF_FFFC, 1'b1, 2'd2, 32'h7FFF_FFFC},  // R10 R5 2 GB offset
    {32'h3FFF_FFFF, 1'b0, 2'd0, 32'h0000_0000}   // R4 below all windows
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] data);
    @(negedge clk);
    cfg_addr = idx;
    #1 data = cfg_rdata;
  endtask

  task automatic do_req(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] rsp_pack();
    return {29'd0, rsp_hit, rsp_win, rsp_local_addr};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      rd(2'(i), rv);
      check("R1 reset word", {32'd0, rv}, 64'd0);
    end
    check("R1 rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
    do_req(32'h0000_0000);
    check("R1 no hit after reset", {31'd0, rsp_valid, rsp_pack()[32:0]}, {31'd0, 1'b1, 33'd0});

    // programming
    wr(2'd0, 32'h4002_0001);   // 4 MB @ 0x4000_0000
    wr(2'd1, 32'h4004_0001);   // 16 MB @ 0x4000_0000
    wr(2'd2, 32'h812B_5A5F);   // 2 GB, junk low base and reserved bits
    rd(2'd2, rv);
    check("R2 readback drops reserved bits", {32'd0, rv}, {32'd0, 32'h812B_0001});
    rd(2'd0, rv);
    check("R2 readback win0", {32'd0, rv}, {32'd0, 32'h4002_0001});

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v][66:35]);
      check($sformatf("R4/R5/R8/R10 vector %0d", v), rsp_pack(),
            {29'd0, VEC[v][34], VEC[v][33:32], VEC[v][31:0]});
    end

    // R9 idle cycle after request
    @(negedge clk);
    check("R9 idle gives no rsp", {62'd0, rsp_valid, rsp_hit}, 64'd0);

    // R3 out-of-range index
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, rv);
    check("R3 index 3 reads zero", {32'd0, rv}, 64'd0);
    rd(2'd0, rv);
    check("R3 win0 untouched", {32'd0, rv}, {32'd0, 32'h4002_0001});
    do_req(32'h4000_1234);
    check("R3 decode unchanged", rsp_pack(), {29'd0, 1'b1, 2'd0, 32'h0000_1234});

    // R6 disable win0
    wr(2'd0, 32'h4002_0000);
    do_req(32'h4000_1234);
    check("R6 disabled win0 skipped", rsp_pack(), {29'd0, 1'b1, 2'd1, 32'h0000_1234});

    // R7 illegal code on win1
    wr(2'd1, 32'h400C_0001);
    rd(2'd1, rv);
    check("R7 code 12 stored", {32'd0, rv}, {32'd0, 32'h400C_0001});
    do_req(32'h4000_1234);
    check("R7 illegal code never hits", {31'd0, rsp_valid, rsp_pack()[32:0]}, {31'd0, 1'b1, 33'd0});
    wr(2'd1, 32'h400F_0001);
    do_req(32'h0000_0000);
    check("R7 code 15 never hits", rsp_pack(), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule